// File: doc/BRIEF.md
# Processor interrupt dispatch controller

This block is the interrupt-handling control of a small processor core. It holds a pending-interrupt register and an enable mask, each with one bit per interrupt line. It also holds a status word that carries the current mask level, an exception-mode flag and a user-mode flag. Every cycle it finds the highest level among the interrupts that are both pending and enabled, and compares that level with the effective mask. When an interrupt wins, the block registers a redirect to the handler vector and updates the status word. For levels of two and above, it also saves the status word and PC into that level's save slots.

Software drives the pending register through separate set and clear write ports. Interrupt lines of the timer type follow their hardware input instead. A small command port carries the other operations: raise-level, wait-for-interrupt, return-from-interrupt, and writes to the status word and to the per-level save slots. The fetched PC is a plain input, and a taken interrupt or a return shows up as a one-cycle redirect pulse with a target PC.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, status_o, pending_o, enable_o, cause_o and old_status_o are zero, and redirect_o and waiting_o are low. In status_o, bits 3:0 hold the mask level, bit 4 the exception flag and bit 5 the user flag.
- R2: Command code 1 (raise) places the previous status_o on old_status_o and loads cmd_arg into status bits 3:0 at the next edge. Bits 5:4 stay unchanged.
- R3: A write on set_bits or clr_bits appears in pending_o after the next clock edge. When both ports name the same software bit, the set wins.
- R4: Timer-type bits (TIMER_MASK, by default bits 0 and 4) copy hw_irq at every edge and ignore the software set and clear ports.
- R5: An interrupt is taken only when it is pending, enabled, and its level is above the effective mask. The effective mask is status bits 3:0, raised to at least EXCM_LVL (default 1) while the exception flag is set. By default bit 2 has level 3, bit 3 has level 2, bit 4 has level 3, and every other bit has level 1.
- R6: Taking a level-1 interrupt sets the exception flag, keeps the mask level, loads cause 4 and pulses redirect_o on the next edge.
- R7: The level-1 redirect target is USER_VEC (default 0x340) when the user flag was set at the moment of entry, and KERNEL_VEC (default 0x300) otherwise.
- R8: Taking a level-N interrupt, with N of 2 or more, copies the status word and cur_pc into save slot N. It then sets the exception flag and mask level N, and redirects to HI_VEC_BASE + N*HI_VEC_STRIDE (default 0x180 + N*0x20).
- R9: When pending, enabled interrupts of different levels compete, the highest level is taken.
- R10: Command code 3 (return) with cmd_arg N between 2 and NUM_LVL loads status from save slot N and redirects to the saved PC of slot N. Codes 5 and 6 write slot N's status and PC from cmd_data. A return naming a level outside that range has no effect.
- R11: Command code 2 (wait) loads cmd_arg into the mask level and raises waiting_o. waiting_o stays high until an interrupt is taken, and it drops at that same edge.
- R12: Command code 4 writes cmd_data[5:0] into the status word. A command arriving in the same cycle as a take is dropped. saved_status_o and saved_pc_o show save slot cmd_arg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NUM_IRQ | Level-sensitive hardware lines for the timer-type bits |
| set_we | input | 1 | Software set write strobe |
| set_bits | input | NUM_IRQ | Pending bits to set |
| clr_we | input | 1 | Software clear write strobe |
| clr_bits | input | NUM_IRQ | Pending bits to clear |
| en_we | input | 1 | Enable mask write strobe |
| en_bits | input | NUM_IRQ | New enable mask |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (1 raise, 2 wait, 3 return, 4 write status, 5 write saved status, 6 write saved PC) |
| cmd_arg | input | 4 | Level operand; also selects the save slot shown on the saved outputs |
| cmd_data | input | PC_W | Write data for the write commands |
| cur_pc | input | PC_W | PC of the current instruction |
| pending_o | output | NUM_IRQ | Pending register |
| enable_o | output | NUM_IRQ | Enable mask |
| status_o | output | 6 | Status word |
| cause_o | output | 6 | Exception cause |
| old_status_o | output | 6 | Status word returned by the last raise |
| waiting_o | output | 1 | Stalled in wait-for-interrupt |
| redirect_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | PC_W | Redirect target |
| saved_status_o | output | 6 | Save slot cmd_arg, status copy |
| saved_pc_o | output | PC_W | Save slot cmd_arg, PC copy |

## Verification
Pending, enable, status, cause, old status and the waiting flag all change at the first edge after the write or command that causes them. A take is decided from registered state, so its redirect comes one edge later: two edges after the write that makes an interrupt both pending and enabled. The same holds for a raise or wait that lowers the mask below a waiting interrupt. The bench drives every input 1 ns after an edge and reads every output 1 ns after the next edge. At the intermediate edge it also checks that no redirect has appeared yet, and one edge after each redirect it checks that no second entry follows.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int PS_W    = 6;
   localparam int LVL_W   = 4;
   localparam int CAUSE_W = 6;
   localparam logic [CAUSE_W-1:0] CAUSE_LVL1 = 6'd4;

   typedef struct packed {
      logic             um;
      logic             excm;
      logic [LVL_W-1:0] lvl;
   } status_t;

   typedef enum logic [2:0] {
      CMD_NONE     = 3'd0,
      CMD_RAISE    = 3'd1,
      CMD_WAIT     = 3'd2,
      CMD_RETURN   = 3'd3,
      CMD_WR_PS    = 3'd4,
      CMD_WR_SV_PS = 3'd5,
      CMD_WR_SV_PC = 3'd6
   } cmd_e;
endpackage

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
   parameter int                 NUM_IRQ    = 16,
   parameter logic [NUM_IRQ-1:0] TIMER_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] hw_irq,
   input  logic               set_we,
   input  logic [NUM_IRQ-1:0] set_bits,
   input  logic               clr_we,
   input  logic [NUM_IRQ-1:0] clr_bits,
   input  logic               en_we,
   input  logic [NUM_IRQ-1:0] en_bits,
   output logic [NUM_IRQ-1:0] pend,
   output logic [NUM_IRQ-1:0] en
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      if (TIMER_MASK[i]) begin : g_hw
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= hw_irq[i];
      end else begin : g_sw
         // set is applied after clear so a collision leaves the bit set
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= (pend[i] & ~(clr_we & clr_bits[i]))
                                   | (set_we & set_bits[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     en <= '0;
      else if (en_we) en <= en_bits;
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick import irq_pkg::*; #(
   parameter int                       NUM_IRQ   = 16,
   parameter logic [NUM_IRQ*LVL_W-1:0] LEVEL_TAB = '0
) (
   input  logic [NUM_IRQ-1:0] active,
   output logic [LVL_W-1:0]   best
);
   always_comb begin
      best = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         logic [LVL_W-1:0] lv;
         lv = LEVEL_TAB[i*LVL_W +: LVL_W];
         if (active[i] && (lv > best)) best = lv;
      end
   end
endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank import irq_pkg::*; #(
   parameter int NUM_LVL = 7,
   parameter int PC_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [LVL_W-1:0] cap_lvl,
   input  status_t          cap_ps,
   input  logic [PC_W-1:0]  cap_pc,
   input  logic             wr_ps_en,
   input  logic             wr_pc_en,
   input  logic [LVL_W-1:0] wr_lvl,
   input  logic [PC_W-1:0]  wr_data,
   input  logic [LVL_W-1:0] rd_lvl,
   output status_t          rd_ps,
   output logic [PC_W-1:0]  rd_pc
);
   logic [NUM_LVL:0][PS_W-1:0] ps_flat;
   logic [NUM_LVL:0][PC_W-1:0] pc_flat;

   for (genvar l = 0; l <= NUM_LVL; l++) begin : g_lvl
      if (l >= 2) begin : g_slot
         logic [PS_W-1:0] ps_q;
         logic [PC_W-1:0] pc_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               ps_q <= '0;
               pc_q <= '0;
            end else if (cap_en && cap_lvl == LVL_W'(l)) begin
               ps_q <= cap_ps;
               pc_q <= cap_pc;
            end else begin
               if (wr_ps_en && wr_lvl == LVL_W'(l)) ps_q <= wr_data[PS_W-1:0];
               if (wr_pc_en && wr_lvl == LVL_W'(l)) pc_q <= wr_data;
            end
         assign ps_flat[l] = ps_q;
         assign pc_flat[l] = pc_q;
      end else begin : g_none
         assign ps_flat[l] = '0;
         assign pc_flat[l] = '0;
      end
   end

   always_comb begin
      rd_ps = '0;
      rd_pc = '0;
      for (int l = 2; l <= NUM_LVL; l++)
         if (rd_lvl == LVL_W'(l)) begin
            rd_ps = status_t'(ps_flat[l]);
            rd_pc = pc_flat[l];
         end
   end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch import irq_pkg::*; #(
   parameter int                       NUM_IRQ       = 16,
   parameter int                       PC_W          = 32,
   parameter int                       NUM_LVL       = 7,
   parameter int                       EXCM_LVL      = 1,
   parameter logic [NUM_IRQ*LVL_W-1:0] LEVEL_TAB     = 64'h1111_1111_1113_2311,
   parameter logic [NUM_IRQ-1:0]       TIMER_MASK    = 16'h0011,
   parameter logic [PC_W-1:0]          KERNEL_VEC    = 32'h0000_0300,
   parameter logic [PC_W-1:0]          USER_VEC      = 32'h0000_0340,
   parameter logic [PC_W-1:0]          HI_VEC_BASE   = 32'h0000_0180,
   parameter logic [PC_W-1:0]          HI_VEC_STRIDE = 32'h0000_0020
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] hw_irq,
   input  logic               set_we,
   input  logic [NUM_IRQ-1:0] set_bits,
   input  logic               clr_we,
   input  logic [NUM_IRQ-1:0] clr_bits,
   input  logic               en_we,
   input  logic [NUM_IRQ-1:0] en_bits,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [LVL_W-1:0]   cmd_arg,
   input  logic [PC_W-1:0]    cmd_data,
   input  logic [PC_W-1:0]    cur_pc,
   output logic [NUM_IRQ-1:0] pending_o,
   output logic [NUM_IRQ-1:0] enable_o,
   output logic [PS_W-1:0]    status_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [PS_W-1:0]    old_status_o,
   output logic               waiting_o,
   output logic               redirect_o,
   output logic [PC_W-1:0]    redirect_pc_o,
   output logic [PS_W-1:0]    saved_status_o,
   output logic [PC_W-1:0]    saved_pc_o
);
   localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(NUM_LVL);
   localparam logic [LVL_W-1:0] EXCM_MIN = LVL_W'(EXCM_LVL);

   // elaboration-time parameter checks
   if (NUM_LVL < 2 || NUM_LVL > (1 << LVL_W) - 1) begin : g_bad_lvl
      $error("NUM_LVL out of range");
   end
   if (EXCM_LVL < 1 || EXCM_LVL > NUM_LVL) begin : g_bad_excm
      $error("EXCM_LVL out of range");
   end
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tab_chk
      if (LEVEL_TAB[i*LVL_W +: LVL_W] == 0 ||
          LEVEL_TAB[i*LVL_W +: LVL_W] > NUM_LVL) begin : g_bad
         $error("LEVEL_TAB entry out of range");
      end
   end

   logic [NUM_IRQ-1:0] pend, en;
   logic [LVL_W-1:0]   best_lvl, eff_mask;
   logic               take, cmd_hit, arg_ok;
   status_t            st_q, st_d, sv_ps;
   logic [PC_W-1:0]    sv_pc;
   logic [CAUSE_W-1:0] cause_q, cause_d;
   status_t            old_q, old_d;
   logic               wait_q, wait_d, redir_q, redir_d;
   logic [PC_W-1:0]    rpc_q, rpc_d;

   irq_pend_regs #(.NUM_IRQ(NUM_IRQ), .TIMER_MASK(TIMER_MASK)) u_pend (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
      .set_we(set_we), .set_bits(set_bits),
      .clr_we(clr_we), .clr_bits(clr_bits),
      .en_we(en_we), .en_bits(en_bits),
      .pend(pend), .en(en));

   irq_level_pick #(.NUM_IRQ(NUM_IRQ), .LEVEL_TAB(LEVEL_TAB)) u_pick (
      .active(pend & en), .best(best_lvl));

   // exception mode lifts the mask to at least EXCM_MIN
   always_comb begin
      eff_mask = st_q.lvl;
      if (st_q.excm && eff_mask < EXCM_MIN) eff_mask = EXCM_MIN;
   end
   assign take    = best_lvl > eff_mask;
   assign cmd_hit = cmd_valid && !take;
   assign arg_ok  = (cmd_arg >= LVL_W'(2)) && (cmd_arg <= TOP_LVL);

   irq_save_bank #(.NUM_LVL(NUM_LVL), .PC_W(PC_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cap_en(take && best_lvl >= LVL_W'(2)), .cap_lvl(best_lvl),
      .cap_ps(st_q), .cap_pc(cur_pc),
      .wr_ps_en(cmd_hit && cmd_e'(cmd_op) == CMD_WR_SV_PS && arg_ok),
      .wr_pc_en(cmd_hit && cmd_e'(cmd_op) == CMD_WR_SV_PC && arg_ok),
      .wr_lvl(cmd_arg), .wr_data(cmd_data),
      .rd_lvl(cmd_arg), .rd_ps(sv_ps), .rd_pc(sv_pc));

   always_comb begin
      st_d    = st_q;
      cause_d = cause_q;
      old_d   = old_q;
      wait_d  = wait_q;
      redir_d = 1'b0;
      rpc_d   = rpc_q;
      if (take) begin
         wait_d   = 1'b0;
         redir_d  = 1'b1;
         st_d.excm = 1'b1;
         if (best_lvl == LVL_W'(1)) begin
            cause_d = CAUSE_LVL1;
            rpc_d   = st_q.um ? USER_VEC : KERNEL_VEC;
         end else begin
            st_d.lvl = best_lvl;
            rpc_d    = HI_VEC_BASE + PC_W'(best_lvl) * HI_VEC_STRIDE;
         end
      end else if (cmd_valid) begin
         case (cmd_e'(cmd_op))
            CMD_RAISE: begin
               old_d    = st_q;
               st_d.lvl = cmd_arg;
            end
            CMD_WAIT: begin
               st_d.lvl = cmd_arg;
               wait_d   = 1'b1;
            end
            CMD_RETURN: if (arg_ok) begin
               st_d    = sv_ps;
               redir_d = 1'b1;
               rpc_d   = sv_pc;
            end
            CMD_WR_PS: st_d = status_t'(cmd_data[PS_W-1:0]);
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st_q    <= '0;
         cause_q <= '0;
         old_q   <= '0;
         wait_q  <= 1'b0;
         redir_q <= 1'b0;
         rpc_q   <= '0;
      end else begin
         st_q    <= st_d;
         cause_q <= cause_d;
         old_q   <= old_d;
         wait_q  <= wait_d;
         redir_q <= redir_d;
         rpc_q   <= rpc_d;
      end

   assign pending_o      = pend;
   assign enable_o       = en;
   assign status_o       = st_q;
   assign cause_o        = cause_q;
   assign old_status_o   = old_q;
   assign waiting_o      = wait_q;
   assign redirect_o     = redir_q;
   assign redirect_pc_o  = rpc_q;
   assign saved_status_o = sv_ps;
   assign saved_pc_o     = sv_pc;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk import irq_pkg::*; #(
   parameter int                 NUM_IRQ    = 16,
   parameter logic [NUM_IRQ-1:0] TIMER_MASK = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] hw_irq,
   input logic               set_we,
   input logic [NUM_IRQ-1:0] set_bits,
   input logic               cmd_valid,
   input logic [2:0]         cmd_op,
   input logic [LVL_W-1:0]   cmd_arg,
   input logic               take,
   input logic [LVL_W-1:0]   best,
   input logic [NUM_IRQ-1:0] pending,
   input logic [PS_W-1:0]    status,
   input logic [CAUSE_W-1:0] cause,
   input logic [PS_W-1:0]    old_status,
   input logic               waiting,
   input logic               redirect
);
   p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && !take) |=>
         (old_status == $past(status) && status[5:4] == $past(status[5:4])
          && status[3:0] == $past(cmd_arg)));

   p_set_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((pending & $past(set_bits) & ~TIMER_MASK)
                  == ($past(set_bits) & ~TIMER_MASK)));

   p_timer_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pending ^ $past(hw_irq)) & TIMER_MASK) == '0));

   p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !(cmd_valid && cmd_op == 3'd3)) |=> !redirect);

   p_lvl1_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && best == 4'd1) |=>
         (redirect && status[4] && cause == 6'd4
          && status[3:0] == $past(status[3:0])));

   p_hi_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && best >= 4'd2) |=>
         (redirect && status[4] && status[3:0] == $past(best)));

   p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !take) |=> waiting);

   p_wait_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !waiting);
endmodule

bind irq_dispatch irq_dispatch_chk #(.NUM_IRQ(NUM_IRQ), .TIMER_MASK(TIMER_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .set_we(set_we), .set_bits(set_bits),
   .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
   .take(take), .best(best_lvl), .pending(pending_o), .status(status_o),
   .cause(cause_o), .old_status(old_status_o), .waiting(waiting_o),
   .redirect(redirect_o));

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic [15:0] hw_irq = '0, set_bits = '0, clr_bits = '0, en_bits = '0;
   logic        set_we = 0, clr_we = 0, en_we = 0, cmd_valid = 0;
   logic [2:0]  cmd_op = '0;
   logic [3:0]  cmd_arg = '0;
   logic [31:0] cmd_data = '0, cur_pc = 32'h0000_1234;
   logic [15:0] pending_o, enable_o;
   logic [5:0]  status_o, cause_o, old_status_o, saved_status_o;
   logic        waiting_o, redirect_o;
   logic [31:0] redirect_pc_o, saved_pc_o;
   int          n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   irq_dispatch u0 (.*);

   // {set, clr, expected pending}, enable stays zero
   localparam logic [47:0] PEND_VEC [6] = '{
      {16'h0002, 16'h0000, 16'h0002},
      {16'h000C, 16'h0000, 16'h000E},
      {16'h0000, 16'h0002, 16'h000C},
      {16'h0011, 16'h0000, 16'h000C},
      {16'h0100, 16'h0100, 16'h010C},
      {16'h0000, 16'hFFFF, 16'h0000}};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_cmd(input logic [2:0] op, input logic [3:0] arg, input logic [31:0] d);
      cmd_valid = 1; cmd_op = op; cmd_arg = arg; cmd_data = d;
      tick();
      cmd_valid = 0; cmd_op = 3'd0;
   endtask

   task automatic wr_set(input logic [15:0] b);
      set_we = 1; set_bits = b; tick(); set_we = 0;
   endtask
   task automatic wr_clr(input logic [15:0] b);
      clr_we = 1; clr_bits = b; tick(); clr_we = 0;
   endtask
   task automatic wr_en(input logic [15:0] b);
      en_we = 1; en_bits = b; tick(); en_we = 0;
   endtask
   task automatic cleanup();
      wr_en(16'h0); wr_clr(16'hFFFF); do_cmd(3'd4, 4'd0, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      check("R1 status", status_o, 0);
      check("R1 pending", pending_o, 0);
      check("R1 enable", enable_o, 0);
      check("R1 cause", cause_o, 0);
      check("R1 old", old_status_o, 0);
      check("R1 redirect", redirect_o, 0);
      check("R1 waiting", waiting_o, 0);

      // table walk: software set/clear with nothing enabled
      foreach (PEND_VEC[k]) begin
         set_we = 1; set_bits = PEND_VEC[k][47:32];
         clr_we = 1; clr_bits = PEND_VEC[k][31:16];
         tick();
         set_we = 0; clr_we = 0;
         check("R3 R4 pending", pending_o, PEND_VEC[k][15:0]);
         check("R5 disabled no entry", redirect_o, 0);
      end

      // R4: timer bits follow the hardware line
      hw_irq = 16'h0011; tick();
      check("R4 hw high", pending_o, 16'h0011);
      wr_clr(16'h0011);
      check("R4 clear ignored", pending_o, 16'h0011);
      hw_irq = 16'h0000; tick();
      check("R4 hw low", pending_o, 16'h0000);

      // R2: raise keeps bits 5:4
      do_cmd(3'd4, 4'd0, 32'h30);
      check("R12 write status", status_o, 6'h30);
      do_cmd(3'd1, 4'd5, 32'h0);
      check("R2 old status", old_status_o, 6'h30);
      check("R2 new status", status_o, 6'h35);
      do_cmd(3'd4, 4'd0, 32'h0);

      // R6/R7: level-1 kernel entry
      wr_set(16'h0002);
      wr_en(16'h0002);
      check("R6 not yet", redirect_o, 0);
      tick();
      check("R6 redirect", redirect_o, 1);
      check("R7 kernel vec", redirect_pc_o, 32'h300);
      check("R6 status", status_o, 6'h10);
      check("R6 cause", cause_o, 6'd4);
      tick();
      check("R5 excm masks level1", redirect_o, 0);
      cleanup();

      // R7: user vector
      do_cmd(3'd4, 4'd0, 32'h20);
      wr_set(16'h0002);
      wr_en(16'h0002);
      tick();
      check("R7 user redirect", redirect_o, 1);
      check("R7 user vec", redirect_pc_o, 32'h340);
      check("R6 user status", status_o, 6'h30);
      cleanup();

      // R5: masked at level 1, released by raise to 0
      do_cmd(3'd4, 4'd0, 32'h01);
      wr_set(16'h0002);
      wr_en(16'h0002);
      tick();
      check("R5 level not above mask", redirect_o, 0);
      do_cmd(3'd1, 4'd0, 32'h0);
      check("R2 old after raise", old_status_o, 6'h01);
      check("R2 lowered", status_o, 6'h00);
      tick();
      check("R5 entry after lowering", redirect_o, 1);
      check("R5 vec", redirect_pc_o, 32'h300);
      cleanup();

      // R8/R9: levels 1, 3, 2 together
      wr_set(16'h000E);
      wr_en(16'h000E);
      tick();
      check("R9 redirect", redirect_o, 1);
      check("R9 level3 vec", redirect_pc_o, 32'h1E0);
      check("R8 status", status_o, 6'h13);
      cmd_arg = 4'd3; #1;
      check("R8 saved status", saved_status_o, 6'h00);
      check("R8 saved pc", saved_pc_o, 32'h1234);
      tick();
      check("R8 no re-entry", redirect_o, 0);

      // R10: return through rewritten save slot
      do_cmd(3'd5, 4'd3, 32'h03);
      do_cmd(3'd6, 4'd3, 32'h4000);
      check("R10 slot status write", saved_status_o, 6'h03);
      check("R10 slot pc write", saved_pc_o, 32'h4000);
      do_cmd(3'd3, 4'd3, 32'h0);
      check("R10 redirect", redirect_o, 1);
      check("R10 target", redirect_pc_o, 32'h4000);
      check("R10 status", status_o, 6'h03);
      do_cmd(3'd3, 4'd1, 32'h0);
      check("R10 bad level no redirect", redirect_o, 0);
      check("R10 bad level status", status_o, 6'h03);
      cleanup();

      // R11: wait for a level-2 interrupt
      wr_en(16'h0008);
      do_cmd(3'd2, 4'd1, 32'h0);
      check("R11 waiting", waiting_o, 1);
      check("R11 level", status_o, 6'h01);
      tick(); tick();
      check("R11 still waiting", waiting_o, 1);
      check("R11 no redirect", redirect_o, 0);
      wr_set(16'h0008);
      check("R11 wait before take", waiting_o, 1);
      tick();
      check("R11 redirect", redirect_o, 1);
      check("R11 level2 vec", redirect_pc_o, 32'h1C0);
      check("R11 released", waiting_o, 0);
      check("R8 level2 status", status_o, 6'h12);
      cmd_arg = 4'd2; #1;
      check("R8 level2 saved status", saved_status_o, 6'h01);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule